// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block connects a clocked system to an external asynchronous static RAM of 1M words by 8 bits. The user side takes one request at a time: an address, write data and a read/write flag, qualified by a valid strobe. While an access is in flight the block holds `busy` high. At the end of every access it raises `done` for one clock. On reads it also updates `rd_data` with the word captured from the memory.

The memory side drives a 20-bit address, a low-active and a high-active chip select, a low-active output enable, and a low-active write strobe. The data bus is split into an output word, an input word and a drive enable, so a pad ring can build the tri-state buffer.

All memory timing comes from nanosecond minimums and the clock period, given as parameters. Each minimum is rounded up to whole clocks. Between accesses both chip selects sit in their inactive (standby) levels. After each read, a turnaround window keeps the controller off the bus until the memory has released it.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and after reset, and whenever `busy` is low, `mem_sel_n`=1, `mem_sel`=0, `mem_rd_n`=1, `mem_wr_n`=1 and `mem_dq_oe`=0.
- R2: A request is taken only in a cycle where `req_valid`=1 and `busy`=0. A `req_valid` pulse while `busy`=1 is ignored and leaves the memory contents unchanged.
- R3: A read (`req_write`=0) selects the memory with `mem_rd_n`=0 and `mem_wr_n`=1 for RD_CYC clocks (9 at default parameters, 8 ns clock). `done` is sampled high RD_CYC+1 clocks after the accepting edge, and `rd_data` then holds the addressed word.
- R4: A write (`req_write`=1) asserts both chip selects and `mem_wr_n`=0 in the same cycle. It holds `mem_wr_n` low for exactly WE_CYC clocks (9 at defaults) and keeps `mem_rd_n`=1 throughout.
- R5: A write ends on the rising edge of `mem_wr_n`. At that edge both chip selects are still active and the write data is still driven, so the addressed word takes the written value.
- R6: After a read, the controller does not drive `mem_dq_oe` until at least TURN_CYC clocks (4 at defaults) have passed since `mem_rd_n` rose.
- R7: `done` is high for exactly one clock per access. Writes leave `rd_data` unchanged.
- R8: `mem_dq_oe` is never high while `mem_rd_n` is low.
- R9: `busy` is high for RD_CYC+TURN_CYC clocks on a read and WE_CYC+1 clocks on a write, counted from the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Access in progress; new requests ignored |
| done | output | 1 | One-clock pulse at the end of each access |
| rd_data | output | 8 | Last word read |
| mem_addr | output | 20 | Memory address |
| mem_sel_n | output | 1 | Low-active chip select |
| mem_sel | output | 1 | High-active chip select |
| mem_rd_n | output | 1 | Low-active output enable |
| mem_wr_n | output | 1 | Low-active write strobe |
| mem_dq_o | output | 8 | Data driven to the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | 8 | Data received from the memory |

## Verification
The main sequence is a table of writes and reads. It covers the lowest and highest addresses, all-ones and all-zeros data, and overwriting a word with new data. Reading back after a write separates a write that lands on the closing strobe edge from one that never commits. Back-to-back write-after-read pairs expose a missing turnaround window. A request pulsed while busy, followed by a read-back, distinguishes an ignored request from one that was latched. Latency, strobe width and busy length are counted at the pins for each access, so a miscounted timer shows up even when the data is right.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WLOW,
        ST_WHOLD
    } sc_state_e;

    // Memory-side control levels; one register drives all of them.
    typedef struct packed {
        logic sel_n;
        logic sel;
        logic rd_n;
        logic wr_n;
        logic dq_oe;
    } sc_pins_t;

    localparam sc_pins_t PINS_IDLE = '{sel_n: 1'b1, sel: 1'b0, rd_n: 1'b1, wr_n: 1'b1, dq_oe: 1'b0};

    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic sc_pins_t pins_for(input sc_state_e s);
        sc_pins_t p;
        p = PINS_IDLE;
        case (s)
            ST_READ: begin
                p.sel_n = 1'b0; p.sel = 1'b1; p.rd_n = 1'b0;
            end
            ST_WLOW: begin
                p.sel_n = 1'b0; p.sel = 1'b1; p.wr_n = 1'b0; p.dq_oe = 1'b1;
            end
            ST_WHOLD: begin
                p.sel_n = 1'b0; p.sel = 1'b1; p.dq_oe = 1'b1;
            end
            default: p = PINS_IDLE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sc_timer.sv
module sc_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sc_fsm.sv
module sc_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CW       = 4,
    parameter int RD_CYC   = 9,
    parameter int WE_CYC   = 9,
    parameter int TURN_CYC = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          t_zero,
    output sc_state_e     state_d,
    output logic          busy,
    output logic          t_load,
    output logic [CW-1:0] t_val,
    output logic          accept,
    output logic          capture,
    output logic          done
);
    sc_state_e state_q;

    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        accept  = 1'b0;
        capture = 1'b0;
        case (state_q)
            ST_IDLE: if (req_valid) begin
                accept = 1'b1;
                t_load = 1'b1;
                if (req_write) begin
                    state_d = ST_WLOW;
                    t_val   = CW'(WE_CYC - 1);
                end else begin
                    state_d = ST_READ;
                    t_val   = CW'(RD_CYC - 1);
                end
            end
            ST_READ: if (t_zero) begin
                capture = 1'b1;
                state_d = ST_TURN;
                t_load  = 1'b1;
                t_val   = CW'(TURN_CYC - 1);
            end
            ST_TURN:  if (t_zero) state_d = ST_IDLE;
            ST_WLOW:  if (t_zero) state_d = ST_WHOLD;
            ST_WHOLD: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= capture || (state_q == ST_WHOLD);
        end
    end

    assign busy = (state_q != ST_IDLE);

    // R7: the completion strobe never lasts two clocks
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R2: a taken request always leaves the idle state
    a_r2_accept_leaves_idle: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);
endmodule

// File: rtl/sc_datapath.sv
module sc_datapath #(
    parameter int AW = 20,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] mem_dq_i,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) rdata_q <= mem_dq_i;
        end
    end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW         = 20,
    parameter int DW         = 8,
    parameter int T_CLK_NS   = 8,
    parameter int T_ACC_NS   = 70,
    parameter int T_RC_NS    = 70,
    parameter int T_PWE_NS   = 55,
    parameter int T_AW_NS    = 65,
    parameter int T_SD_NS    = 30,
    parameter int T_WC_NS    = 70,
    parameter int T_OFF_NS   = 25
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_sel_n,
    output logic          mem_sel,
    output logic          mem_rd_n,
    output logic          mem_wr_n,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_i
);
    localparam int RD_CYC   = imax(1, imax(cdiv(T_ACC_NS, T_CLK_NS), cdiv(T_RC_NS, T_CLK_NS)));
    localparam int WE_CYC   = imax(1, imax(imax(cdiv(T_PWE_NS, T_CLK_NS), cdiv(T_AW_NS, T_CLK_NS)),
                                           imax(cdiv(T_SD_NS, T_CLK_NS), cdiv(T_WC_NS, T_CLK_NS) - 1)));
    localparam int TURN_CYC = imax(1, cdiv(T_OFF_NS, T_CLK_NS));
    localparam int CNT_MAX  = imax(RD_CYC, imax(WE_CYC, TURN_CYC));
    localparam int CW       = $clog2(CNT_MAX + 1);

    sc_state_e     state_d;
    logic          t_load, t_zero, accept, capture;
    logic [CW-1:0] t_val;
    sc_pins_t      pins_q;

    sc_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
    );

    sc_fsm #(.CW(CW), .RD_CYC(RD_CYC), .WE_CYC(WE_CYC), .TURN_CYC(TURN_CYC)) u_fsm (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .t_zero(t_zero), .state_d(state_d), .busy(busy), .t_load(t_load),
        .t_val(t_val), .accept(accept), .capture(capture), .done(done)
    );

    sc_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk(clk), .rst(rst), .accept(accept), .capture(capture),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_i(mem_dq_i),
        .addr_q(mem_addr), .wdata_q(mem_dq_o), .rdata_q(rd_data)
    );

    // Control pins come straight from a register, so they cannot glitch.
    always_ff @(posedge clk) begin
        if (rst) pins_q <= PINS_IDLE;
        else     pins_q <= pins_for(state_d);
    end

    assign mem_sel_n = pins_q.sel_n;
    assign mem_sel   = pins_q.sel;
    assign mem_rd_n  = pins_q.rd_n;
    assign mem_wr_n  = pins_q.wr_n;
    assign mem_dq_oe = pins_q.dq_oe;

    // Clocks since the memory's output enable was last active (saturating).
    logic [7:0] off_gap_q;
    always_ff @(posedge clk) begin
        if (rst)                 off_gap_q <= 8'hFF;
        else if (!mem_rd_n)      off_gap_q <= 8'h00;
        else if (off_gap_q != 8'hFF) off_gap_q <= off_gap_q + 8'h01;
    end

    // R1: standby levels whenever no access is in progress
    a_r1_idle_deselect: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (mem_sel_n && !mem_sel && mem_rd_n && mem_wr_n && !mem_dq_oe));
    // R4: write strobe only with both selects active and output enable off
    a_r4_strobe_needs_select: assert property (@(posedge clk) disable iff (rst)
        !mem_wr_n |-> (!mem_sel_n && mem_sel && mem_rd_n && mem_dq_oe));
    // R5: closing edge of a write keeps selects, address and data
    a_r5_close_on_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_wr_n) |-> (!mem_sel_n && mem_sel && mem_dq_oe
                             && $stable(mem_addr) && $stable(mem_dq_o)));
    // R8: never drive while the memory may drive
    a_r8_no_contention: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_rd_n);
    // R6: turnaround window before the controller takes the bus
    a_r6_turnaround: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> (int'(off_gap_q) >= TURN_CYC));
    // R3: address held steady while the memory stays selected
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));
endmodule

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;
    // Timing counts at defaults with an 8 ns clock.
    localparam int RD_N   = 9;
    localparam int WE_N   = 9;
    localparam int TURN_N = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, done;
    logic [7:0]  rd_data;
    logic [19:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_rd_n, mem_wr_n, mem_dq_oe;
    logic [7:0]  mem_dq_o, mem_dq_i;

    always #4 clk = ~clk;

    sram_async_ctrl dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n),
        .mem_sel(mem_sel), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // Memory model: test addresses differ in their low byte.
    logic [7:0] mdl [256];
    int contention = 0;
    assign mem_dq_i = (!mem_sel_n && mem_sel && !mem_rd_n && mem_wr_n) ? mdl[mem_addr[7:0]] : 8'h00;
    always @(posedge mem_wr_n)
        if (!mem_sel_n && mem_sel && mem_dq_oe) mdl[mem_addr[7:0]] <= mem_dq_o;

    int gap = 1000, min_gap = 1000;
    logic prev_oe = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_rd_n && mem_dq_oe) contention++;
            if (!mem_rd_n) gap = 0;
            else begin
                if (mem_dq_oe && !prev_oe && gap < min_gap) min_gap = gap;
                gap++;
            end
            prev_oe = mem_dq_oe;
        end
    end

    int total = 0, failed = 0;
    task automatic chk(input string rq, input int act, input int exp);
        total++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", total - failed, total);
        $finish;
    endtask

    int r_done_at, r_busy_len, r_we_low, r_done_cnt, r_rdlow;
    task automatic access(input logic wr, input logic [19:0] a, input logic [7:0] d);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1; r_done_at = 0; r_busy_len = 0; r_we_low = 0; r_done_cnt = 0; r_rdlow = 0;
        while (n < 1000) begin
            if (done) begin r_done_cnt++; if (r_done_at == 0) r_done_at = n; end
            if (!busy) break;
            r_busy_len++;
            if (!mem_wr_n) r_we_low++;
            if (!mem_rd_n) r_rdlow++;
            @(negedge clk);
            n++;
        end
    endtask

    // {write, address, data or expected read value}
    localparam logic [28:0] VEC [10] = '{
        {1'b1, 20'h00000, 8'hA5}, {1'b1, 20'hFFFFF, 8'h3C}, {1'b1, 20'h12345, 8'h01},
        {1'b0, 20'h00000, 8'hA5}, {1'b0, 20'hFFFFF, 8'h3C}, {1'b0, 20'h12345, 8'h01},
        {1'b1, 20'h00000, 8'hFF}, {1'b0, 20'h00000, 8'hFF},
        {1'b1, 20'hABC10, 8'h00}, {1'b0, 20'hABC10, 8'h00}
    };

    initial begin
        #(8 * 150000);
        failed++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        logic [7:0] last_rd;
        for (int i = 0; i < 256; i++) mdl[i] = 8'h5A;
        repeat (3) @(negedge clk);
        // R1: reset levels
        chk("R1 reset pins", {mem_sel_n, mem_sel, mem_rd_n, mem_wr_n, mem_dq_oe}, 5'b10110);
        chk("R1 reset busy", busy, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle pins", {mem_sel_n, mem_sel, mem_rd_n, mem_wr_n, mem_dq_oe}, 5'b10110);
        last_rd = 8'h00;
        for (int i = 0; i < 10; i++) begin
            logic wr; logic [19:0] a; logic [7:0] d;
            {wr, a, d} = VEC[i];
            access(wr, a, d);
            chk("R7 done once", r_done_cnt, 1);
            if (wr) begin
                chk("R4 strobe width", r_we_low, WE_N);
                chk("R9 write busy", r_busy_len, WE_N + 1);
                chk("R3 write done", r_done_at, WE_N + 2);
                chk("R7 rd_data kept", rd_data, last_rd);
            end else begin
                chk("R3 read data", rd_data, d);
                chk("R3 read done", r_done_at, RD_N + 1);
                chk("R3 read enable", r_rdlow, RD_N);
                chk("R9 read busy", r_busy_len, RD_N + TURN_N);
                last_rd = rd_data;
            end
            chk("R1 idle after", {mem_sel_n, mem_sel, mem_rd_n, mem_wr_n, mem_dq_oe}, 5'b10110);
        end
        // R5: overwritten word holds its last value in the memory itself
        chk("R5 array", mdl[8'h00], 8'hFF);
        // R2: request during busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h12345;
        @(negedge clk);
        req_write = 1'b1; req_wdata = 8'h77;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        chk("R2 first read", rd_data, 8'h01);
        access(1'b0, 20'h12345, 8'h00);
        chk("R2 ignored write", rd_data, 8'h01);
        // R6: write straight after read
        access(1'b1, 20'h12345, 8'hC3);
        access(1'b0, 20'h12345, 8'h00);
        chk("R5 readback", rd_data, 8'hC3);
        chk("R6 turnaround", (min_gap >= TURN_N) ? 1 : 0, 1);
        chk("R8 contention", contention, 0);
        summary();
    end
endmodule